// File: doc/BRIEF.md
# Abortable Iterative Multiplier

This block multiplies two 32-bit operands by shift-and-add. It examines one multiplier bit per clock and keeps only the least-significant 32 bits of the product. A multiply occupies the unit for 32 clock cycles. At the end, a one-cycle completion pulse is raised and the product register is loaded. The product register then holds that value until the next multiply completes.

The unit sits beside an interrupt controller. Its abandon input is driven by the pending-interrupt signal. When that input is raised while a multiply is running, the work is discarded on the next clock edge. No completion pulse is produced and the product register is left untouched, so the interrupt is never held back. The caller later reissues the multiply, and it runs again from the first bit.

A start request that arrives while a multiply is running is ignored. The exception is when abandon is raised in the same cycle: then the old work is dropped and the new operands are loaded in one step.

Top module: `iter_mul32`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `startReq` sampled at a clock edge while idle loads `opA` and `opB`. `busy` is 1 for exactly the 32 cycles that follow that edge.
- R3: `done` is a single-cycle pulse. It appears 32 cycles after the start edge, in the same cycle `busy` falls.
- R4: When `done` is 1, `product` equals (`opA` × `opB`) mod 2^32, using the operands captured at the start edge.
- R5: `product` changes only in the cycle `done` rises. It holds while idle and throughout a later multiply.
- R6: `abortReq` sampled at an edge while busy, with `startReq` low, has three effects at that edge. `busy` falls, no `done` pulse follows, and `product` keeps its previous value. This applies even in the last cycle of a multiply.
- R7: `startReq` without `abortReq` while busy is ignored. The running multiply finishes at its original time with its original operands.
- R8: `startReq` together with `abortReq` while busy discards the running multiply and loads the new operands. `done` then follows 32 cycles after that edge, with the new product.
- R9: `abortReq` while idle has no effect: `busy` stays 0, no `done`, and `product` is unchanged.
- R10: After an abandoned multiply, a new start runs the full 32 cycles from scratch and yields the correct product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Begin a multiply with the present operands |
| abortReq | input | 1 | Abandon the running multiply (pending interrupt) |
| opA | input | 32 | Multiplicand |
| opB | input | 32 | Multiplier |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse: product was just loaded |
| product | output | 32 | Low 32 bits of the last completed product |

## Verification
A wrong iteration count shows at the ports as a completion pulse one or more cycles away from the 32nd cycle after the start edge. It is caught on the first multiply. A corrupted shift or accumulate register shows only in the value loaded at completion, so many operand pairs are compared against a truncated reference product. Mishandling of abandon or of an ignored start shows in three ways. A stray completion pulse can arrive with no expected result queued. The product register can change without a pulse. Or `busy` can stay high in the cycle after the abandon edge.

// File: rtl/iter_mul_pkg.sv
package iter_mul_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic commit;
  } mulCtl_t;
endpackage

// File: rtl/iter_mul_ctrl.sv
module iter_mul_ctrl
  import iter_mul_pkg::*;
#(
  parameter int STEPS = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    abortReq,
  output logic    busy,
  output logic    done,
  output mulCtl_t ctl
);
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  logic             running;
  logic [CNT_W-1:0] count;
  logic             lastStep;

  assign lastStep = (count == LAST);

  always_comb begin
    ctl.load   = startReq && (!running || abortReq);
    ctl.step   = running && !abortReq;
    ctl.commit = running && !abortReq && lastStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      count   <= '0;
      done    <= 1'b0;
    end else begin
      done <= ctl.commit;
      if (ctl.load) begin
        running <= 1'b1;
        count   <= '0;
      end else if (running) begin
        if (abortReq || lastStep) begin
          running <= 1'b0;
          count   <= '0;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

  assign busy = running;

  // R3: completion is never longer than one cycle
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: abandon empties the unit at once and suppresses completion
  assert_abort_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (running && abortReq && !startReq) |=> (!running && !done));

  // R7: a plain start while running does not disturb the iteration
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (running && startReq && !abortReq && !lastStep) |=> (running && count == $past(count) + 1'b1));

  // R8: start with abandon restarts from the first bit
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (running && startReq && abortReq) |=> (running && count == '0 && !done));

  // R9: abandon while idle changes nothing
  assert_idle_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!running && abortReq && !startReq) |=> (!running && !done));

  // R2: an idle start engages the unit on the next cycle
  assert_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!running && startReq) |=> (running && count == '0));
endmodule

// File: rtl/iter_mul_dp.sv
module iter_mul_dp
  import iter_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulCtl_t          ctl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] mcand;
  logic [WIDTH-1:0] mplr;
  logic [WIDTH-1:0] acc;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sum;

  assign addend = mplr[0] ? mcand : '0;
  assign sum    = acc + addend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcand <= '0;
      mplr  <= '0;
      acc   <= '0;
    end else if (ctl.load) begin
      mcand <= opA;
      mplr  <= opB;
      acc   <= '0;
    end else if (ctl.step) begin
      mcand <= mcand << 1;
      mplr  <= mplr >> 1;
      acc   <= sum;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) result <= '0;
    else if (ctl.commit) result <= sum;
  end

  // R5: the product register moves only on a commit strobe
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> $stable(result));

  // R8: a load always clears the accumulator for a fresh pass
  assert_load_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (acc == '0));
endmodule

// File: rtl/iter_mul32.sv
module iter_mul32
  import iter_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             abortReq,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] product
);
  mulCtl_t ctl;

  iter_mul_ctrl #(.STEPS(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .busy(busy), .done(done), .ctl(ctl)
  );

  iter_mul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opA(opA), .opB(opB), .result(product)
  );
endmodule

// File: tb/sim_iter_mul32.sv
module sim_iter_mul32;
  typedef struct {
    logic [31:0] val;
    int          cyc;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        abortReq = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        busy;
  logic        done;
  logic [31:0] product;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic [31:0] lastGood = '0;
  expItem_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  iter_mul32 u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .opA(opA), .opB(opB), .busy(busy), .done(done), .product(product)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected results as completions appear
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R6/R9 unexpected done", 32'(cyc), 32'hffffffff);
      end else begin
        expItem_t it;
        it = sb.pop_front();
        check(product == it.val, "R4 product", product, it.val);
        check(cyc == it.cyc, "R3 done timing", 32'(cyc), 32'(it.cyc));
        check(!busy, "R3 busy low with done", 32'(busy), 32'd0);
        lastGood = it.val;
      end
    end
  end

  task automatic drain();
    repeat (36) @(negedge clk);
  endtask

  // full multiply with per-cycle busy and hold checks (R2, R5)
  task automatic runOp(input logic [31:0] a, input logic [31:0] b);
    int c;
    logic [31:0] prev;
    @(negedge clk);
    prev = lastGood;
    c = cyc;
    opA = a; opB = b; startReq = 1'b1;
    sb.push_back('{val: a * b, cyc: c + 33});
    @(negedge clk);
    startReq = 1'b0; opA = $urandom; opB = $urandom;
    check(busy == 1'b1, "R2 busy after start", 32'(busy), 32'd1);
    for (int i = 2; i <= 32; i++) begin
      @(negedge clk);
      if (i == 32) check(busy == 1'b1, "R2 busy in 32nd cycle", 32'(busy), 32'd1);
      if (i == 16) check(product == prev, "R5 product holds mid-run", product, prev);
    end
    @(negedge clk);
    check(busy == 1'b0, "R2 busy drops", 32'(busy), 32'd0);
    @(negedge clk);
    check(product == a * b, "R5 product holds after done", product, a * b);
  endtask

  task automatic abortAt(input int k);
    logic [31:0] prev;
    @(negedge clk);
    prev = lastGood;
    opA = $urandom; opB = $urandom; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (k - 1) @(negedge clk);
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    check(busy == 1'b0, "R6 busy falls on abort", 32'(busy), 32'd0);
    check(product == prev, "R6 product kept on abort", product, prev);
    repeat (36) @(negedge clk);
    check(product == prev, "R6 no late result", product, prev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy reset", 32'(busy), 32'd0);
    check(done == 1'b0, "R1 done reset", 32'(done), 32'd0);
    check(product == 32'd0, "R1 product reset", product, 32'd0);
    rstN = 1'b1;

    // R4 directed corners
    runOp(32'd0, 32'hdeadbeef);
    runOp(32'hffffffff, 32'hffffffff);
    runOp(32'h80000000, 32'd3);
    runOp(32'd1, 32'h12345678);
    runOp(32'h0001_0000, 32'h0001_0000);
    for (int n = 0; n < 20; n++) runOp($urandom, $urandom);

    // R6 abort at first, last and random cycles
    abortAt(1);
    abortAt(32);
    for (int n = 0; n < 6; n++) abortAt(1 + ($urandom % 32));

    // R10 full rerun after an abandon
    runOp(32'h0badf00d, 32'h13579bdf);

    // R9 abort while idle
    begin
      logic [31:0] prev;
      @(negedge clk);
      prev = product;
      abortReq = 1'b1;
      @(negedge clk);
      abortReq = 1'b0;
      check(busy == 1'b0, "R9 idle abort keeps idle", 32'(busy), 32'd0);
      @(negedge clk);
      check(product == prev, "R9 idle abort keeps product", product, prev);
    end

    // R7 start while busy ignored
    begin
      int c;
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      @(negedge clk);
      c = cyc;
      opA = a; opB = b; startReq = 1'b1;
      sb.push_back('{val: a * b, cyc: c + 33});
      @(negedge clk);
      startReq = 1'b0;
      repeat (9) @(negedge clk);
      opA = $urandom; opB = $urandom; startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      check(busy == 1'b1, "R7 still busy", 32'(busy), 32'd1);
      drain();
      check(product == a * b, "R7 original product", product, a * b);
    end

    // R8 restart with start plus abort
    for (int n = 0; n < 3; n++) begin
      int c;
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      @(negedge clk);
      opA = $urandom; opB = $urandom; startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      repeat (4 + n * 10) @(negedge clk);
      c = cyc;
      opA = a; opB = b; startReq = 1'b1; abortReq = 1'b1;
      sb.push_back('{val: a * b, cyc: c + 33});
      @(negedge clk);
      startReq = 1'b0; abortReq = 1'b0;
      check(busy == 1'b1, "R8 busy after restart", 32'(busy), 32'd1);
      drain();
      check(product == a * b, "R8 restarted product", product, a * b);
    end

    drain();
    check(sb.size() == 0, "R3 all results seen", 32'(sb.size()), 32'd0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 32'(cyc), 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule